// File: doc/BRIEF.md
# PHY Reset and Receive-Lock Sequencer

This block runs the fixed bring-up script for a serial PHY once its reference clock has been switched on. It does not touch the PHY itself. It drives a register-access handshake engine that sits between it and the PHY control port. Each access is one of three operations: load an address, write data to the loaded address, or read from the loaded address. The sequencer asks for one operation at a time and waits for the engine to answer with completion or with an error.

After a start pulse the sequencer waits a settling interval. It then loads the clock-reset register address and writes the reset-enable value. After a second settling interval it polls the lane status register with an address load followed by a read. It repeats the poll, with a longer gap between attempts, until the receive-PLL-stable bit reads as one or the read budget runs out. All intervals are counted in pulses of an external timebase tick, so the delays do not depend on the system clock frequency.

The outcome is reported on three sticky flags (locked, timed out, failed) and a finished flag. All of them hold their values until the next start.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, the request, locked, timeout, error and finished outputs are all low.
- R2: A start while idle or finished clears all outcome flags. It then waits exactly PRE_RESET_TICKS timebase ticks, counting only ticks sampled after the start. Next it requests an address operation (op code 0) with data 0x7F3F. Ticks sampled while a request is outstanding are not counted toward any wait.
- R3: When the address operation completes, the next request is a write operation (op code 1) with data 0x0001, issued in the cycle right after the completion.
- R4: When the write completes, the block waits exactly POST_RESET_TICKS ticks. It then requests an address operation with data 0x2003, followed directly by a read operation (op code 2) that carries data 0x0000.
- R5: A read that completes with bit 1 of the returned data set ends the sequence with the locked flag high and the finished flag high.
- R6: A read that completes with bit 1 clear, when fewer than MAX_READS reads have been made, causes a wait of exactly POLL_GAP_TICKS ticks. The block then issues another address-0x2003 and read pair.
- R7: If the MAX_READS-th read completes with bit 1 clear, the sequence ends with the timeout flag high, after exactly MAX_READS reads.
- R8: An error response to any request ends the sequence at once with the error flag high and no further requests. When error and completion arrive in the same cycle, the error takes precedence.
- R9: A request stays high with its op code and data unchanged until completion or error is returned.
- R10: The outcome flags and the finished flag keep their values until the next start. A start received while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the bring-up sequence (honoured when idle or finished) |
| tick_i | input | 1 | Timebase pulse, one cycle wide, that paces every wait |
| cr_req_o | output | 1 | Operation request to the handshake engine |
| cr_op_o | output | 2 | Operation code: 0 address, 1 write, 2 read |
| cr_data_o | output | 16 | Address or write value for the requested operation |
| cr_done_i | input | 1 | Engine reports the current operation complete |
| cr_err_i | input | 1 | Engine reports the current operation failed |
| cr_rdata_i | input | 16 | Read result, valid with cr_done_i on a read |
| locked_o | output | 1 | Receive PLL seen stable |
| timeout_o | output | 1 | Read budget used up without lock |
| error_o | output | 1 | Sequence aborted on an engine error |
| done_o | output | 1 | Sequence finished, held until the next start |

## Verification
The engine can return an error and a completion in the same cycle, and the two imply different next states. Error must win: the block must finish with only the error flag set and must issue no further request. The bench model of the engine asserts both strobes together on a randomly chosen operation, including the final read and a read that carries the lock bit. In each of these runs it checks that the error flag is the only outcome flag set and that the count of operations stops at the failed one.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } cr_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_RST_ADDR,
    ST_RST_WR,
    ST_POST,
    ST_STAT_ADDR,
    ST_STAT_RD,
    ST_GAP,
    ST_FIN
  } seq_st_e;

  localparam logic [15:0] REG_CLK_RESET = 16'h7F3F;
  localparam logic [15:0] VAL_RESET_EN  = 16'h0001;
  localparam logic [15:0] REG_LANE_STAT = 16'h2003;
  localparam int          LOCK_BIT      = 1;

  // Receive PLL reported stable in a lane status word
  function automatic logic lane_stable(input logic [15:0] word);
    return word[LOCK_BIT];
  endfunction

  // Counter width able to hold the longest of three tick delays
  function automatic int delay_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (m < 1) m = 1;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/phy_seq_tick_delay.sv
module phy_seq_tick_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load_i)                  cnt_q <= len_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/phy_seq_read_budget.sv
module phy_seq_read_budget #(
  parameter int MAX_READS = 6,
  localparam int RD_W = $clog2(MAX_READS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            count_i,
  output logic [RD_W-1:0] used_o,
  output logic            last_o
);
  logic [RD_W-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       used_q <= '0;
    else if (clear_i) used_q <= '0;
    else if (count_i) used_q <= used_q + 1'b1;
  end

  assign used_o = used_q;
  assign last_o = (used_q == RD_W'(MAX_READS - 1));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int PRE_RESET_TICKS  = 100,
  parameter int POST_RESET_TICKS = 100,
  parameter int POLL_GAP_TICKS   = 1000,
  parameter int MAX_READS        = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        tick_i,
  output logic        cr_req_o,
  output logic [1:0]  cr_op_o,
  output logic [15:0] cr_data_o,
  input  logic        cr_done_i,
  input  logic        cr_err_i,
  input  logic [15:0] cr_rdata_i,
  output logic        locked_o,
  output logic        timeout_o,
  output logic        error_o,
  output logic        done_o
);
  localparam int TMR_W = delay_width(PRE_RESET_TICKS, POST_RESET_TICKS, POLL_GAP_TICKS);
  localparam int RD_W  = $clog2(MAX_READS + 1);
  localparam logic [TMR_W-1:0] PRE_LEN  = TMR_W'(PRE_RESET_TICKS);
  localparam logic [TMR_W-1:0] POST_LEN = TMR_W'(POST_RESET_TICKS);
  localparam logic [TMR_W-1:0] GAP_LEN  = TMR_W'(POLL_GAP_TICKS);

  seq_st_e st_q, st_d;
  logic tmr_load, tmr_expire;
  logic [TMR_W-1:0] tmr_len;
  logic rd_clear, rd_count, rd_last;
  logic [RD_W-1:0] reads_used;
  logic locked_q, timeout_q, error_q;
  logic locked_d, timeout_d, error_d;

  // Named events, also observed by the checker
  logic xfer_ok, xfer_fail, stat_seen, busy;
  assign xfer_ok   = cr_req_o && cr_done_i && !cr_err_i;
  assign xfer_fail = cr_req_o && cr_err_i;
  assign stat_seen = lane_stable(cr_rdata_i);
  assign busy      = (st_q != ST_IDLE) && (st_q != ST_FIN);

  phy_seq_tick_delay #(.CNT_W(TMR_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .len_i(tmr_len),
    .tick_i(tick_i), .expire_o(tmr_expire)
  );

  phy_seq_read_budget #(.MAX_READS(MAX_READS)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear_i(rd_clear), .count_i(rd_count),
    .used_o(reads_used), .last_o(rd_last)
  );

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_len   = '0;
    rd_clear  = 1'b0;
    rd_count  = 1'b0;
    locked_d  = locked_q;
    timeout_d = timeout_q;
    error_d   = error_q;
    if (xfer_fail) begin
      st_d    = ST_FIN;
      error_d = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE, ST_FIN: if (start_i) begin
          st_d      = ST_PRE;
          tmr_load  = 1'b1;
          tmr_len   = PRE_LEN;
          rd_clear  = 1'b1;
          locked_d  = 1'b0;
          timeout_d = 1'b0;
          error_d   = 1'b0;
        end
        ST_PRE:      if (tmr_expire) st_d = ST_RST_ADDR;
        ST_RST_ADDR: if (xfer_ok)    st_d = ST_RST_WR;
        ST_RST_WR:   if (xfer_ok) begin
          st_d     = ST_POST;
          tmr_load = 1'b1;
          tmr_len  = POST_LEN;
        end
        ST_POST:      if (tmr_expire) st_d = ST_STAT_ADDR;
        ST_STAT_ADDR: if (xfer_ok)    st_d = ST_STAT_RD;
        ST_STAT_RD:   if (xfer_ok) begin
          rd_count = 1'b1;
          if (stat_seen) begin
            st_d     = ST_FIN;
            locked_d = 1'b1;
          end else if (rd_last) begin
            st_d      = ST_FIN;
            timeout_d = 1'b1;
          end else begin
            st_d     = ST_GAP;
            tmr_load = 1'b1;
            tmr_len  = GAP_LEN;
          end
        end
        ST_GAP:  if (tmr_expire) st_d = ST_STAT_ADDR;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      locked_q  <= 1'b0;
      timeout_q <= 1'b0;
      error_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      locked_q  <= locked_d;
      timeout_q <= timeout_d;
      error_q   <= error_d;
    end
  end

  always_comb begin
    cr_req_o  = 1'b1;
    cr_op_o   = OP_ADDR;
    cr_data_o = '0;
    case (st_q)
      ST_RST_ADDR:  cr_data_o = REG_CLK_RESET;
      ST_RST_WR:    begin cr_op_o = OP_WRITE; cr_data_o = VAL_RESET_EN; end
      ST_STAT_ADDR: cr_data_o = REG_LANE_STAT;
      ST_STAT_RD:   cr_op_o = OP_READ;
      default:      cr_req_o = 1'b0;
    endcase
  end

  assign locked_o  = locked_q;
  assign timeout_o = timeout_q;
  assign error_o   = error_q;
  assign done_o    = (st_q == ST_FIN);
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk
  import phy_seq_pkg::*;
#(
  parameter int MAX_READS = 6,
  localparam int RD_W = $clog2(MAX_READS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            cr_req_o,
  input logic [1:0]      cr_op_o,
  input logic [15:0]     cr_data_o,
  input logic            cr_done_i,
  input logic            cr_err_i,
  input logic [15:0]     cr_rdata_i,
  input logic            locked_o,
  input logic            timeout_o,
  input logic            error_o,
  input logic            done_o,
  input logic            busy,
  input logic [RD_W-1:0] reads_used
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cr_req_o && !cr_done_i && !cr_err_i |=> cr_req_o && $stable(cr_op_o) && $stable(cr_data_o));

  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({locked_o, timeout_o, error_o}));

  assert_err_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_req_o && cr_err_i |=> done_o && error_o && !cr_req_o);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cr_req_o);

  assert_lock_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(cr_req_o && cr_done_i && !cr_err_i &&
                              cr_op_o == OP_READ && cr_rdata_i[LOCK_BIT]));

  assert_timeout_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> reads_used == RD_W'(MAX_READS));

  assert_read_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reads_used <= RD_W'(MAX_READS));

  assert_write_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cr_req_o && cr_op_o == OP_WRITE |-> cr_data_o == 16'h0001);

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) || (busy && !cr_req_o) |=>
      $stable(locked_o) && $stable(timeout_o) && $stable(error_o));
endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(.MAX_READS(MAX_READS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cr_req_o(cr_req_o),
  .cr_op_o(cr_op_o), .cr_data_o(cr_data_o), .cr_done_i(cr_done_i),
  .cr_err_i(cr_err_i), .cr_rdata_i(cr_rdata_i), .locked_o(locked_o),
  .timeout_o(timeout_o), .error_o(error_o), .done_o(done_o),
  .busy(busy), .reads_used(reads_used)
);

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
  localparam int PRE_T  = 5;
  localparam int POST_T = 7;
  localparam int GAP_T  = 20;
  localparam int MAXR   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, tick_i = 1'b0;
  logic cr_done_i = 1'b0, cr_err_i = 1'b0;
  logic [15:0] cr_rdata_i = '0;
  logic cr_req_o, locked_o, timeout_o, error_o, done_o;
  logic [1:0] cr_op_o;
  logic [15:0] cr_data_o;

  always #4 clk = ~clk;

  phy_bringup_seq #(.PRE_RESET_TICKS(PRE_T), .POST_RESET_TICKS(POST_T),
                    .POLL_GAP_TICKS(GAP_T), .MAX_READS(MAXR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .cr_req_o(cr_req_o), .cr_op_o(cr_op_o), .cr_data_o(cr_data_o),
    .cr_done_i(cr_done_i), .cr_err_i(cr_err_i), .cr_rdata_i(cr_rdata_i),
    .locked_o(locked_o), .timeout_o(timeout_o), .error_o(error_o), .done_o(done_o));

  int tests = 0, fails = 0;
  int tick_total = 0;
  int t_last = 0;
  int txn_idx = 0;
  int g_lock_read = 0;
  int g_err_idx = -1;
  bit g_err_done = 1'b0;

  always @(posedge clk) if (rst_n && tick_i) tick_total <= tick_total + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_op(input int i);
    if (i == 1) return 1;
    if (i == 0 || i % 2 == 0) return 0;
    return 2;
  endfunction

  function automatic int exp_data(input int i);
    if (i == 0) return 16'h7F3F;
    if (i == 1) return 16'h0001;
    if (i % 2 == 0) return 16'h2003;
    return 0;
  endfunction

  function automatic int exp_gap(input int i);
    if (i == 0) return PRE_T;
    if (i == 2) return POST_T;
    if (i % 2 == 1) return 0;
    return GAP_T;
  endfunction

  function automatic string req_of(input int i);
    if (i == 0) return "R2";
    if (i == 1) return "R3";
    if (i < 4) return "R4";
    return "R6";
  endfunction

  function automatic int nominal_txns(input int lock_read);
    if (lock_read >= 1 && lock_read <= MAXR) return 2 + 2 * lock_read;
    return 2 + 2 * MAXR;
  endfunction

  task automatic serve();
    int idx, gap, lat, rn;
    logic [1:0] op;
    logic [15:0] d;
    idx = txn_idx;
    gap = tick_total - t_last;
    op = cr_op_o;
    d = cr_data_o;
    check(int'(op) == exp_op(idx), req_of(idx), "op code", int'(op), exp_op(idx));
    check(int'(d) == exp_data(idx), req_of(idx), "data", int'(d), exp_data(idx));
    check(gap == exp_gap(idx), req_of(idx), "tick gap", gap, exp_gap(idx));
    lat = int'($urandom % 3);
    repeat (lat) begin
      @(negedge clk);
      check(cr_req_o && cr_op_o == op && cr_data_o == d, "R9", "request held",
            int'(cr_req_o), 1);
    end
    if (idx == g_err_idx) begin
      cr_err_i = 1'b1;
      cr_done_i = g_err_done;
    end else begin
      cr_done_i = 1'b1;
      if (op == 2'd2) begin
        rn = (idx - 1) / 2;
        if (rn == g_lock_read) cr_rdata_i = 16'($urandom) | 16'h0002;
        else                   cr_rdata_i = 16'($urandom) & 16'hFFFD;
      end
    end
    txn_idx++;
    @(negedge clk);
    cr_done_i = 1'b0;
    cr_err_i = 1'b0;
    cr_rdata_i = '0;
    t_last = tick_total;
  endtask

  task automatic master_loop();
    @(negedge clk);
    forever begin
      if (cr_req_o) serve();
      else @(negedge clk);
    end
  endtask

  task automatic tick_loop();
    forever begin
      @(negedge clk);
      tick_i = ($urandom % 2) == 0;
    end
  endtask

  task automatic run_seq(input int lock_read, input int err_idx,
                         input bit err_done, input bit mid_start);
    int cyc, nom, exp_n;
    bit exp_l, exp_t, exp_e;
    bit lk, tm, er;
    g_lock_read = lock_read;
    g_err_idx = err_idx;
    g_err_done = err_done;
    txn_idx = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t_last = tick_total;
    check(!locked_o && !timeout_o && !error_o && !done_o, "R10", "flags cleared by start",
          int'({locked_o, timeout_o, error_o, done_o}), 0);
    cyc = 0;
    while (!done_o && cyc < 5000) begin
      if (mid_start && cyc == 15 && !done_o) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    nom = nominal_txns(lock_read);
    exp_e = (err_idx >= 0);
    exp_n = exp_e ? err_idx + 1 : nom;
    exp_l = !exp_e && lock_read >= 1 && lock_read <= MAXR;
    exp_t = !exp_e && !exp_l;
    check(done_o, "R10", "finished flag", int'(done_o), 1);
    check(txn_idx == exp_n, exp_e ? "R8" : (exp_l ? "R5" : "R7"), "operation count",
          txn_idx, exp_n);
    check(locked_o == exp_l, "R5", "locked flag", int'(locked_o), int'(exp_l));
    check(timeout_o == exp_t, "R7", "timeout flag", int'(timeout_o), int'(exp_t));
    check(error_o == exp_e, "R8", "error flag", int'(error_o), int'(exp_e));
    lk = locked_o; tm = timeout_o; er = error_o;
    repeat (12) @(negedge clk);
    check(!cr_req_o && done_o && locked_o == lk && timeout_o == tm && error_o == er,
          "R10", "outcome held after finish", int'({cr_req_o, done_o}), 1);
  endtask

  task automatic main();
    int nom, e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!cr_req_o && !locked_o && !timeout_o && !error_o && !done_o, "R1",
          "outputs in reset", int'({cr_req_o, locked_o, timeout_o, error_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(!cr_req_o && !done_o, "R1", "idle after reset", int'({cr_req_o, done_o}), 0);
    // directed corner cases
    run_seq(1, -1, 1'b0, 1'b0);        // R5 lock on first read
    run_seq(MAXR, -1, 1'b0, 1'b0);     // R5 lock on last permitted read
    run_seq(0, -1, 1'b0, 1'b0);        // R7 timeout
    run_seq(0, -1, 1'b0, 1'b1);        // R10 start while running
    run_seq(2, 0, 1'b0, 1'b0);         // R8 error on first operation
    run_seq(0, 2 + 2 * MAXR - 1, 1'b1, 1'b0); // R8 error with done on final read
    run_seq(3, 7, 1'b1, 1'b0);         // R8 error with done on a locking read
    // constrained random runs
    for (int n = 0; n < 30; n++) begin
      int lr;
      lr = int'($urandom % (MAXR + 2));
      nom = nominal_txns(lr);
      e = (($urandom % 3) == 0) ? int'($urandom % nom) : -1;
      run_seq(lr, e, $urandom % 2 == 0, $urandom % 4 == 0);
    end
  endtask

  initial begin
    fork
      master_loop();
      tick_loop();
    join_none
    fork
      main();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule